// File: doc/BRIEF.md
# Serial Unit Status Flag Register

This block keeps the eight-bit status word of a synchronous serial unit. The shift engine sends it single-cycle event strobes: a received byte has landed, transmit data has moved into the shift register, and the last transmit bit has left. The bus side sends strobes for status reads and writes, for writes to the transmit data register and for reads of the receive data register. The block also watches the transmit-enable bit, the four-wire mode bit, the master/slave bit and the chip-select pin level. It drives the assembled status word and a receive-inhibit line back to the shift engine.

Software cannot set a flag. It can clear one only with a handshake: a status read must first return the flag as 1, and then the following status write must carry a 0 in that bit position. Each flag tracks this qualification on its own. A hardware set event that lands in the same cycle as any clear wins. An overrun stops further reception until software clears it. The conflict flag watches the chip-select pin in a different way for master and for slave operation in four-wire mode.

Top module: `ser_stat_flags`

## Requirements
- R1: The status word carries the conflict flag at bit 0, overrun at bit 2, receive-full at bit 5, transmit-end at bit 6 and transmit-empty at bit 7. Bits 1, 3 and 4 always read 0 and ignore writes.
- R2: An active-low asynchronous reset clears every status bit and deasserts receive-inhibit.
- R3: Writing a 1 to any flag leaves it unchanged. A write of 0 clears a flag only if the most recent status read, with no other status write after it, returned that flag as 1.
- R4: Each status write uses up the read qualification of every flag. A flag that was 0 at the status read and was then set by hardware is not cleared by the write that follows.
- R5: When a hardware set event and a clear (hardware or software) reach the same flag in the same cycle, the flag ends the cycle at 1.
- R6: Receive-full is set one cycle after a receive-complete strobe and clears one cycle after a receive-data read strobe.
- R7: A receive-complete strobe while receive-full is 1 sets overrun. While overrun is 1, receive-inhibit is 1 and receive-complete strobes change neither receive-full nor overrun.
- R8: Transmit-empty is set when transmit-enable rises from 0 to 1 and on every load strobe into the shift register. A transmit-data write strobe clears both transmit-empty and transmit-end.
- R9: Transmit-end is set by a last-bit strobe only while transmit-empty is 1.
- R10: In four-wire mode as master, a transfer-start strobe with chip-select low sets the conflict flag. A start in three-wire mode, or with chip-select high, does not.
- R11: In four-wire mode as slave, a low-to-high change of chip-select while the transfer-busy input is 1 sets the conflict flag. The same change with busy at 0 does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stat_rd_i | input | 1 | Status register read strobe |
| stat_wr_i | input | 1 | Status register write strobe |
| stat_wdata_i | input | 8 | Status write data |
| txd_wr_i | input | 1 | Transmit data register write strobe |
| rxd_rd_i | input | 1 | Receive data register read strobe |
| rx_done_i | input | 1 | Received byte placed in receive data register |
| tx_load_i | input | 1 | Transmit data moved into shift register |
| tx_last_i | input | 1 | Last transmit bit sent |
| tx_en_i | input | 1 | Transmit enable level |
| four_wire_i | input | 1 | Four-wire mode select |
| master_i | input | 1 | 1 = master, 0 = slave |
| cs_n_i | input | 1 | Chip-select pin level (synchronised), low active |
| xfer_start_i | input | 1 | Transfer start strobe |
| xfer_busy_i | input | 1 | Transfer in progress |
| status_o | output | 8 | Status word |
| rx_inhibit_o | output | 1 | Reception blocked by overrun |

## Verification
The hardest state to reach is a flag that was 0 when status was read, was then set by hardware, and then receives a write of 0. The bench reaches it by reading status while transmit-end is 0, pulsing last-bit while transmit-empty is 1, and then writing zeros. It checks that only the pre-armed transmit-empty clears. A second hard case puts a load strobe in the same cycle as an armed software clear of transmit-empty, to check that the set wins. The overrun lock is reached by two back-to-back receive strobes. A third strobe is then issued after receive-full was drained, to show that it is ignored.

// File: rtl/ser_stat_pkg.sv
package ser_stat_pkg;
  localparam int unsigned REG_W = 8;
  localparam int unsigned NFLAG = 5;

  // flag index order inside the block
  localparam int unsigned F_CE   = 0;
  localparam int unsigned F_ORER = 1;
  localparam int unsigned F_RDRF = 2;
  localparam int unsigned F_TEND = 3;
  localparam int unsigned F_TDRE = 4;

  // bit position of each flag in the status word
  localparam int unsigned FLAG_POS [NFLAG] = '{0, 2, 5, 6, 7};
endpackage

// File: rtl/ser_flag_cell.sv
module ser_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic hw_clr_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o
);
  logic flag_q, arm_q;
  logic sw_clr;
  logic flag_d, arm_d;

  assign sw_clr = wr_i && arm_q && !wbit_i;

  always_comb begin
    flag_d = set_i | (flag_q & ~hw_clr_i & ~sw_clr);
    if (rd_i)      arm_d = flag_q;
    else if (wr_i) arm_d = 1'b0;
    else           arm_d = arm_q & flag_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign flag_o = flag_q;

  p_set_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);

  p_write_one_keeps_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wbit_i && !hw_clr_i && flag_o) |=> flag_o);

  p_fall_has_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_o) |-> $past(hw_clr_i || wr_i));

  p_unread_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !rd_i && flag_o && !hw_clr_i && !arm_q) |=> flag_o);
endmodule

// File: rtl/ser_flag_events.sv
module ser_flag_events
  import ser_stat_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NFLAG-1:0] flags_i,
  input  logic             txd_wr_i,
  input  logic             rxd_rd_i,
  input  logic             rx_done_i,
  input  logic             tx_load_i,
  input  logic             tx_last_i,
  input  logic             tx_en_i,
  input  logic             four_wire_i,
  input  logic             master_i,
  input  logic             cs_n_i,
  input  logic             xfer_start_i,
  input  logic             xfer_busy_i,
  output logic [NFLAG-1:0] set_o,
  output logic [NFLAG-1:0] clr_o
);
  logic tx_en_q, cs_n_q;
  logic tx_en_rise, cs_rise, rx_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_en_q <= 1'b0;
      cs_n_q  <= 1'b1;
    end else begin
      tx_en_q <= tx_en_i;
      cs_n_q  <= cs_n_i;
    end
  end

  assign tx_en_rise = tx_en_i && !tx_en_q;
  assign cs_rise    = cs_n_i && !cs_n_q;
  assign rx_ok      = rx_done_i && !flags_i[F_ORER];

  always_comb begin
    set_o = '0;
    clr_o = '0;
    set_o[F_RDRF] = rx_ok;
    set_o[F_ORER] = rx_ok && flags_i[F_RDRF];
    set_o[F_TDRE] = tx_en_rise || tx_load_i;
    set_o[F_TEND] = tx_last_i && flags_i[F_TDRE];
    set_o[F_CE]   = four_wire_i &&
                    ((master_i && xfer_start_i && !cs_n_i) ||
                     (!master_i && xfer_busy_i && cs_rise));
    clr_o[F_RDRF] = rxd_rd_i;
    clr_o[F_TDRE] = txd_wr_i;
    clr_o[F_TEND] = txd_wr_i;
  end

  p_slave_ce_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (four_wire_i && !master_i && xfer_busy_i && cs_n_i && !$past(cs_n_i))
      |-> set_o[F_CE]);
endmodule

// File: rtl/ser_stat_flags.sv
module ser_stat_flags
  import ser_stat_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stat_rd_i,
  input  logic             stat_wr_i,
  input  logic [REG_W-1:0] stat_wdata_i,
  input  logic             txd_wr_i,
  input  logic             rxd_rd_i,
  input  logic             rx_done_i,
  input  logic             tx_load_i,
  input  logic             tx_last_i,
  input  logic             tx_en_i,
  input  logic             four_wire_i,
  input  logic             master_i,
  input  logic             cs_n_i,
  input  logic             xfer_start_i,
  input  logic             xfer_busy_i,
  output logic [REG_W-1:0] status_o,
  output logic             rx_inhibit_o
);
  logic [NFLAG-1:0] flags, set_v, clr_v;

  ser_flag_events u_events (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flags_i      (flags),
    .txd_wr_i     (txd_wr_i),
    .rxd_rd_i     (rxd_rd_i),
    .rx_done_i    (rx_done_i),
    .tx_load_i    (tx_load_i),
    .tx_last_i    (tx_last_i),
    .tx_en_i      (tx_en_i),
    .four_wire_i  (four_wire_i),
    .master_i     (master_i),
    .cs_n_i       (cs_n_i),
    .xfer_start_i (xfer_start_i),
    .xfer_busy_i  (xfer_busy_i),
    .set_o        (set_v),
    .clr_o        (clr_v)
  );

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    ser_flag_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_i    (set_v[i]),
      .hw_clr_i (clr_v[i]),
      .rd_i     (stat_rd_i),
      .wr_i     (stat_wr_i),
      .wbit_i   (stat_wdata_i[FLAG_POS[i]]),
      .flag_o   (flags[i])
    );
  end

  always_comb begin
    status_o = '0;
    for (int i = 0; i < NFLAG; i++) status_o[FLAG_POS[i]] = flags[i];
  end

  assign rx_inhibit_o = flags[F_ORER];

  p_overrun_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_i && status_o[FLAG_POS[F_RDRF]] && !rx_inhibit_o)
      |=> status_o[FLAG_POS[F_ORER]]);

  p_inhibit_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_inhibit_o && rx_done_i && !rxd_rd_i && !stat_wr_i)
      |=> $stable(status_o[FLAG_POS[F_RDRF]]));

  p_tend_needs_tdre_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[FLAG_POS[F_TEND]])
      |-> $past(tx_last_i && status_o[FLAG_POS[F_TDRE]]));

  p_tdre_rise_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[FLAG_POS[F_TDRE]]) |-> $past(tx_load_i || tx_en_i));

  p_rxd_rd_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rxd_rd_i && !rx_done_i) |=> !status_o[FLAG_POS[F_RDRF]]);
endmodule

// File: tb/tb_ser_stat_flags.sv
`timescale 1ns/1ps
module tb_ser_stat_flags;
  localparam int NV = 38;

  typedef struct packed {
    logic [3:0] req;
    logic rd, wr;
    logic [7:0] wd;
    logic txw, rxr, rxd, ld, last, ten, fw, ms, csn, st, busy;
    logic [7:0] exp;
    logic inh;
  } vec_t;

  function automatic vec_t mk(int req, bit rd, bit wr, logic [7:0] wd, bit txw,
      bit rxr, bit rxd, bit ld, bit last, bit ten, bit fw, bit ms, bit csn,
      bit st, bit busy, logic [7:0] exp, bit inh);
    vec_t v;
    v.req = 4'(req); v.rd = rd; v.wr = wr; v.wd = wd; v.txw = txw; v.rxr = rxr;
    v.rxd = rxd; v.ld = ld; v.last = last; v.ten = ten; v.fw = fw; v.ms = ms;
    v.csn = csn; v.st = st; v.busy = busy; v.exp = exp; v.inh = inh;
    return v;
  endfunction

  // status bits: CE=01 ORER=04 RDRF=20 TEND=40 TDRE=80
  //                req rd wr wd   txw rxr rxd ld last ten fw ms csn st busy exp inh
  localparam vec_t VEC [NV] = '{
    mk( 2, 0,0,8'h00, 0,0,0,0,0, 0, 0,0,1,0,0, 8'h00,0), // R2 idle
    mk( 8, 0,0,8'h00, 0,0,0,0,0, 1, 0,0,1,0,0, 8'h80,0), // R8 enable rise
    mk( 8, 0,0,8'h00, 1,0,0,0,0, 1, 0,0,1,0,0, 8'h00,0), // R8 txd write
    mk( 8, 0,0,8'h00, 0,0,0,1,0, 1, 0,0,1,0,0, 8'h80,0), // R8 load
    mk( 9, 0,0,8'h00, 0,0,0,0,1, 1, 0,0,1,0,0, 8'hC0,0), // R9 last with TDRE
    mk( 8, 0,0,8'h00, 1,0,0,0,0, 1, 0,0,1,0,0, 8'h00,0), // R8 clears both
    mk( 9, 0,0,8'h00, 0,0,0,0,1, 1, 0,0,1,0,0, 8'h00,0), // R9 last, TDRE 0
    mk( 8, 0,0,8'h00, 0,0,0,1,0, 1, 0,0,1,0,0, 8'h80,0), // R8
    mk( 6, 0,0,8'h00, 0,0,1,0,0, 1, 0,0,1,0,0, 8'hA0,0), // R6 rx done
    mk( 6, 0,0,8'h00, 0,1,0,0,0, 1, 0,0,1,0,0, 8'h80,0), // R6 rxd read
    mk( 6, 0,0,8'h00, 0,0,1,0,0, 1, 0,0,1,0,0, 8'hA0,0), // R6
    mk( 7, 0,0,8'h00, 0,0,1,0,0, 1, 0,0,1,0,0, 8'hA4,1), // R7 overrun
    mk( 7, 0,0,8'h00, 0,1,0,0,0, 1, 0,0,1,0,0, 8'h84,1), // R7 drain
    mk( 7, 0,0,8'h00, 0,0,1,0,0, 1, 0,0,1,0,0, 8'h84,1), // R7 rx ignored
    mk( 3, 0,1,8'h00, 0,0,0,0,0, 1, 0,0,1,0,0, 8'h84,1), // R3 no read first
    mk( 3, 1,0,8'h00, 0,0,0,0,0, 1, 0,0,1,0,0, 8'h84,1), // R3 read arms
    mk( 1, 0,1,8'hFF, 0,0,0,0,0, 1, 0,0,1,0,0, 8'h84,1), // R1/R3 write ones
    mk( 4, 0,1,8'h00, 0,0,0,0,0, 1, 0,0,1,0,0, 8'h84,1), // R4 arm used up
    mk( 3, 1,0,8'h00, 0,0,0,0,0, 1, 0,0,1,0,0, 8'h84,1), // R3
    mk( 3, 0,1,8'h80, 0,0,0,0,0, 1, 0,0,1,0,0, 8'h80,0), // R3 clear ORER
    mk( 6, 0,0,8'h00, 0,0,1,0,0, 1, 0,0,1,0,0, 8'hA0,0), // R6
    mk( 3, 1,0,8'h00, 0,0,0,0,0, 1, 0,0,1,0,0, 8'hA0,0), // R3 arm
    mk( 5, 0,1,8'h00, 0,0,0,1,0, 1, 0,0,1,0,0, 8'h80,0), // R5 load vs clear
    mk( 4, 1,0,8'h00, 0,0,0,0,0, 1, 0,0,1,0,0, 8'h80,0), // R4 read, TEND 0
    mk( 9, 0,0,8'h00, 0,0,0,0,1, 1, 0,0,1,0,0, 8'hC0,0), // R9
    mk( 4, 0,1,8'h00, 0,0,0,0,0, 1, 0,0,1,0,0, 8'h40,0), // R4 TEND survives
    mk( 8, 0,0,8'h00, 1,0,0,0,0, 1, 0,0,1,0,0, 8'h00,0), // R8
    mk(10, 0,0,8'h00, 0,0,0,0,0, 1, 1,1,0,1,0, 8'h01,0), // R10 master cs low
    mk( 3, 1,0,8'h00, 0,0,0,0,0, 1, 1,1,0,0,0, 8'h01,0), // R3
    mk( 3, 0,1,8'h00, 0,0,0,0,0, 1, 1,1,0,0,0, 8'h00,0), // R3
    mk(10, 0,0,8'h00, 0,0,0,0,0, 1, 0,1,0,1,0, 8'h00,0), // R10 three-wire
    mk(10, 0,0,8'h00, 0,0,0,0,0, 1, 1,1,1,1,0, 8'h00,0), // R10 cs high
    mk(11, 0,0,8'h00, 0,0,0,0,0, 1, 1,0,0,0,1, 8'h00,0), // R11 cs low
    mk(11, 0,0,8'h00, 0,0,0,0,0, 1, 1,0,1,0,1, 8'h01,0), // R11 rise busy
    mk(11, 0,0,8'h00, 0,0,0,0,0, 1, 1,0,0,0,0, 8'h01,0), // R11
    mk( 3, 1,0,8'h00, 0,0,0,0,0, 1, 1,0,0,0,0, 8'h01,0), // R3
    mk( 3, 0,1,8'h00, 0,0,0,0,0, 1, 1,0,0,0,0, 8'h00,0), // R3
    mk(11, 0,0,8'h00, 0,0,0,0,0, 1, 1,0,1,0,0, 8'h00,0)  // R11 rise idle
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic stat_rd, stat_wr, txd_wr, rxd_rd, rx_done, tx_load, tx_last, tx_en;
  logic four_wire, master, cs_n, xfer_start, xfer_busy;
  logic [7:0] stat_wdata, status;
  logic rx_inh;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  ser_stat_flags dut (
    .clk_i(clk), .rst_ni(rst_n), .stat_rd_i(stat_rd), .stat_wr_i(stat_wr),
    .stat_wdata_i(stat_wdata), .txd_wr_i(txd_wr), .rxd_rd_i(rxd_rd),
    .rx_done_i(rx_done), .tx_load_i(tx_load), .tx_last_i(tx_last),
    .tx_en_i(tx_en), .four_wire_i(four_wire), .master_i(master),
    .cs_n_i(cs_n), .xfer_start_i(xfer_start), .xfer_busy_i(xfer_busy),
    .status_o(status), .rx_inhibit_o(rx_inh)
  );

  task automatic apply(vec_t v);
    stat_rd = v.rd; stat_wr = v.wr; stat_wdata = v.wd; txd_wr = v.txw;
    rxd_rd = v.rxr; rx_done = v.rxd; tx_load = v.ld; tx_last = v.last;
    tx_en = v.ten; four_wire = v.fw; master = v.ms; cs_n = v.csn;
    xfer_start = v.st; xfer_busy = v.busy;
  endtask

  task automatic check(string tag, logic [7:0] exp, logic inh);
    checks++;
    if (status !== exp || rx_inh !== inh) begin
      errors++;
      $display("FAIL %s status=%h inh=%b expected status=%h inh=%b",
               tag, status, rx_inh, exp, inh);
    end
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog status=%h expected completion", status);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    apply(mk(0,0,0,8'h00,0,0,0,0,0,0,0,0,1,0,0,8'h00,0));
    #3;
    check("R2 in reset", 8'h00, 1'b0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(VEC[i]);
      @(posedge clk);
      #1;
      check($sformatf("R%0d vec %0d", VEC[i].req, i), VEC[i].exp, VEC[i].inh);
    end

    // R5: hardware clear and set on TDRE in the same cycle
    @(negedge clk);
    apply(mk(0,0,0,8'h00,0,0,0,1,0,1,0,0,1,0,0,8'h00,0));
    @(posedge clk); #1;
    check("R5 load alone", 8'h80, 1'b0);
    @(negedge clk);
    apply(mk(0,0,0,8'h00,1,0,0,1,0,1,0,0,1,0,0,8'h00,0));
    @(posedge clk); #1;
    check("R5 txd write with load", 8'h80, 1'b0);

    // R8: enable low then high again re-sets TDRE after a write cleared it
    @(negedge clk);
    apply(mk(0,0,0,8'h00,1,0,0,0,0,0,0,0,1,0,0,8'h00,0));
    @(posedge clk); #1;
    check("R8 clear, enable low", 8'h00, 1'b0);
    @(negedge clk);
    apply(mk(0,0,0,8'h00,0,0,0,0,0,1,0,0,1,0,0,8'h00,0));
    @(posedge clk); #1;
    check("R8 enable rerise", 8'h80, 1'b0);

    // R2: asynchronous reset mid-operation with overrun pending
    @(negedge clk);
    apply(mk(0,0,0,8'h00,0,0,1,0,0,1,0,0,1,0,0,8'h00,0));
    @(posedge clk); #1;
    @(negedge clk);
    @(posedge clk); #1;
    check("R7 second rx", 8'hA4, 1'b1);
    @(negedge clk);
    apply(mk(0,0,0,8'h00,0,0,0,0,0,1,0,0,1,0,0,8'h00,0));
    #1;
    rst_n = 1'b0;
    #1;
    check("R2 async reset", 8'h00, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule